// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of several DMA request lines is served next and runs the bus-hold handshake with the host processor. Request lines arrive asynchronously. Each one passes through a two-flop synchronizer and is then masked by a controller-off control. While any unmasked request is pending, the arbiter asks for the bus. Once the processor returns its hold acknowledge, the arbiter picks a winner. It drives that channel's acknowledge line and reports the channel number to the transfer engine.

Two priority schemes are available, chosen by a configuration input. In the fixed scheme the lowest channel number always wins. In the rotating scheme the channel served most recently drops to the bottom and the channel after it moves to the top. The acknowledge lines can be active high or active low, and active low is the idle default. The grant holds until the transfer engine reports that it is done. The bus request then drops, and no new request is raised until the processor has taken back its acknowledge.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `hold_req_o` and `grant_valid_o` are 0, and every `ack_o` bit is at its inactive level (1 when `ack_active_high_i` is 0).
- R2: A request is seen only after two synchronizer stages. `hold_req_o` rises on the third rising clock edge after a request line goes high, and not before.
- R3: No acknowledge line goes active before `hold_ack_i` has been seen high. A grant starts on the first edge at which `hold_ack_i` is high and a request is pending.
- R4: With `rotate_i` = 0, the pending channel with the lowest index wins.
- R5: With `rotate_i` = 1, the search starts at the channel after the one last served and wraps around. After reset the search starts at channel 0.
- R6: While `disable_i` = 1, pending requests are ignored and `hold_req_o` stays low. When `disable_i` drops, a request that is already synchronized raises `hold_req_o` on the next edge.
- R7: During a grant exactly one `ack_o` bit is active, at index `grant_id_o`. The active level is 1 when `ack_active_high_i` = 1 and 0 when it is 0.
- R8: `grant_id_o` and `ack_o` stay stable from the start of a grant until `done_i` is seen, even if the request lines change.
- R9: `hold_req_o` falls on the edge that samples `done_i` during a grant. A new bus request is not raised while `hold_ack_i` is still high.
- R10: If every request is withdrawn before `hold_ack_i` arrives, the arbiter returns to idle and `hold_req_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Asynchronous channel request lines |
| disable_i | input | 1 | Controller-off control; masks all requests |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| ack_active_high_i | input | 1 | Acknowledge polarity: 1 for active high, 0 for active low |
| hold_ack_i | input | 1 | Bus hold acknowledge from the processor |
| done_i | input | 1 | Transfer engine signals that the granted transfer is finished |
| hold_req_o | output | 1 | Bus hold request to the processor |
| ack_o | output | NCH | Per-channel acknowledge lines, with programmable polarity |
| grant_valid_o | output | 1 | A channel is currently granted |
| grant_id_o | output | $clog2(NCH) | Index of the granted channel |

## Verification
The in-RTL properties check on every cycle that a grant only begins after hold acknowledge and that at most one acknowledge is active. They also check that the granted index stays frozen until `done_i`, that the bus request drops right after completion and stays low while acknowledge is still high, and that a disabled controller never raises a request. The properties cannot tell which channel should have won. The bench scenarios show that: the fixed order against the rotating order over a sequence of services, the three-edge synchronizer latency, recovery after a withdrawn request, and both acknowledge polarities at the ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_WAIT    = 2'd1,
        ARB_GRANT   = 2'd2,
        ARB_RELEASE = 2'd3
    } arb_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] pending_i,
    input  logic [CW-1:0]  base_i,
    output logic           any_o,
    output logic [CW-1:0]  win_o
);
    int idx;

    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        idx   = 0;
        for (int i = 0; i < NCH; i++) begin
            idx = (int'(base_i) + i) % NCH;
            if (!any_o && pending_i[idx]) begin
                any_o = 1'b1;
                win_o = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic           disable_i,
    input  logic           rotate_i,
    input  logic           ack_active_high_i,
    input  logic           hold_ack_i,
    input  logic           done_i,
    output logic           hold_req_o,
    output logic [NCH-1:0] ack_o,
    output logic           grant_valid_o,
    output logic [CW-1:0]  grant_id_o
);
    typedef struct packed {
        arb_state_e    state;
        logic [CW-1:0] win;
        logic [CW-1:0] last;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [NCH-1:0] req_s;
    logic [NCH-1:0] pending;
    logic [CW-1:0]  base;
    logic           any;
    logic [CW-1:0]  pick;
    logic [NCH-1:0] grant_1h;

    dma_req_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(req_i),
        .sync_o (req_s)
    );

    assign pending = req_s & {NCH{~disable_i}};

    always_comb begin
        if (!rotate_i)                     base = '0;
        else if (r_q.last == CW'(NCH - 1)) base = '0;
        else                               base = r_q.last + 1'b1;
    end

    dma_prio_pick #(.NCH(NCH), .CW(CW)) u_pick (
        .pending_i(pending),
        .base_i   (base),
        .any_o    (any),
        .win_o    (pick)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ARB_IDLE: begin
                if (any && !hold_ack_i) r_d.state = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (hold_ack_i) begin
                    if (any) begin
                        r_d.win   = pick;
                        r_d.state = ARB_GRANT;
                    end else begin
                        r_d.state = ARB_RELEASE;
                    end
                end else if (!any) begin
                    r_d.state = ARB_IDLE;
                end
            end
            ARB_GRANT: begin
                if (done_i) begin
                    r_d.last  = r_q.win;
                    r_d.state = ARB_RELEASE;
                end
            end
            default: begin
                if (!hold_ack_i) r_d.state = ARB_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ARB_IDLE;
            r_q.win   <= '0;
            r_q.last  <= CW'(NCH - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_req_o    = (r_q.state == ARB_WAIT) || (r_q.state == ARB_GRANT);
    assign grant_valid_o = (r_q.state == ARB_GRANT);
    assign grant_id_o    = r_q.win;

    for (genvar c = 0; c < NCH; c++) begin : g_ack
        assign grant_1h[c] = grant_valid_o && (r_q.win == CW'(c));
        assign ack_o[c]    = ack_active_high_i ? grant_1h[c] : ~grant_1h[c];
    end

    // R3
    grant_after_hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid_o) |-> $past(hold_ack_i));

    // R7
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_active_high_i ? ack_o : ~ack_o)
        && (grant_valid_o -> ((ack_active_high_i ? ack_o[grant_id_o] : ~ack_o[grant_id_o]) == 1'b1)));

    // R8
    grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !done_i) |=> (grant_valid_o && $stable(grant_id_o)));

    // R9
    release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i) |=> !hold_req_o);

    // R9
    no_req_while_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req_o && hold_ack_i) |=> !hold_req_o);

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req_o && disable_i) |=> !hold_req_o);
endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] req;
    logic           dis, rot, ack_hi, hold_ack, done;
    logic           hold_req, gvalid;
    logic [NCH-1:0] ack;
    logic [1:0]     gid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_req_arbiter #(.NCH(NCH)) i_dma_req_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .disable_i(dis), .rotate_i(rot),
        .ack_active_high_i(ack_hi), .hold_ack_i(hold_ack), .done_i(done),
        .hold_req_o(hold_req), .ack_o(ack), .grant_valid_o(gvalid), .grant_id_o(gid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [NCH-1:0] exp_ack(input bit hi, input bit active, input int id);
        logic [NCH-1:0] v;
        v = active ? (NCH'(1) << id) : '0;
        return hi ? v : ~v;
    endfunction

    task automatic do_reset(input bit hi, input bit rotate);
        @(negedge clk);
        rst_n = 1'b0; req = '0; dis = 1'b0; rot = rotate; ack_hi = hi;
        hold_ack = 1'b0; done = 1'b0;
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        tick(1);
    endtask

    task automatic serve(input int exp_id, input string tag);
        int n = 0;
        while (!hold_req && n < 40) begin tick(1); n++; end
        chk(hold_req == 1'b1, {tag, " hold_req raised"}, hold_req, 1);
        @(negedge clk) hold_ack = 1'b1;
        tick(1);
        chk(gvalid == 1'b1 && gid == 2'(exp_id), {tag, " grant id"}, gid, exp_id);
        chk(ack == exp_ack(ack_hi, 1'b1, exp_id), "R7 ack level", ack, exp_ack(ack_hi, 1'b1, exp_id));
        @(negedge clk) done = 1'b1;
        tick(1);
        chk(hold_req == 1'b0, "R9 hold_req drop on done", hold_req, 0);
        @(negedge clk) begin done = 1'b0; hold_ack = 1'b0; end
        tick(1);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk(hold_req == 1'b0 && gvalid == 1'b0, "R1 reset outputs", {hold_req, gvalid}, 0);
        chk(ack == 4'hF, "R1 reset ack inactive", ack, 4'hF);
    endtask

    task automatic t_fixed();
        do_reset(1'b0, 1'b0);
        @(negedge clk) req = 4'b1010;
        tick(2);
        chk(hold_req == 1'b0, "R2 no request before sync", hold_req, 0);
        tick(1);
        chk(hold_req == 1'b1, "R2 request on third edge", hold_req, 1);
        tick(2);
        chk(ack == 4'hF && gvalid == 1'b0, "R3 no ack before hold_ack", ack, 4'hF);
        @(negedge clk) hold_ack = 1'b1;
        tick(1);
        chk(gvalid && gid == 2'd1, "R4 lowest pending wins", gid, 1);
        chk(ack == 4'b1101, "R7 active-low ack", ack, 4'b1101);
        @(negedge clk) req = 4'b0001;
        tick(4);
        chk(gvalid && gid == 2'd1 && ack == 4'b1101, "R8 grant held", gid, 1);
        @(negedge clk) done = 1'b1;
        tick(1);
        chk(hold_req == 1'b0 && gvalid == 1'b0, "R9 drop after done", hold_req, 0);
        @(negedge clk) done = 1'b0;
        tick(4);
        chk(hold_req == 1'b0, "R9 no request while hold_ack high", hold_req, 0);
        @(negedge clk) hold_ack = 1'b0;
        tick(1);
        chk(hold_req == 1'b0, "R9 idle after hold_ack low", hold_req, 0);
        tick(1);
        chk(hold_req == 1'b1, "R9 new request after release", hold_req, 1);
        serve(0, "R4 fixed next");
        @(negedge clk) req = 4'b1111;
        tick(3);
        serve(0, "R4 fixed repeat a");
        serve(0, "R4 fixed repeat b");
    endtask

    task automatic t_rotate();
        do_reset(1'b0, 1'b1);
        @(negedge clk) req = 4'b1111;
        serve(0, "R5 rotate start");
        serve(1, "R5 rotate step1");
        serve(2, "R5 rotate step2");
        serve(3, "R5 rotate step3");
        serve(0, "R5 rotate wrap");
        @(negedge clk) req = 4'b0101;
        tick(3);
        serve(2, "R5 rotate skip");
        serve(0, "R5 rotate wrap skip");
    endtask

    task automatic t_disable();
        do_reset(1'b0, 1'b0);
        @(negedge clk) begin dis = 1'b1; req = 4'b0100; end
        tick(6);
        chk(hold_req == 1'b0 && ack == 4'hF, "R6 disabled ignores request", hold_req, 0);
        @(negedge clk) dis = 1'b0;
        tick(1);
        chk(hold_req == 1'b1, "R6 request after enable", hold_req, 1);
        serve(2, "R6 served after enable");
    endtask

    task automatic t_polarity();
        do_reset(1'b1, 1'b0);
        chk(ack == 4'h0, "R1 active-high idle ack", ack, 0);
        @(negedge clk) req = 4'b1100;
        serve(2, "R7 active-high grant");
        chk(ack == 4'h0, "R7 active-high released", ack, 0);
    endtask

    task automatic t_withdraw();
        do_reset(1'b0, 1'b0);
        @(negedge clk) req = 4'b0010;
        tick(3);
        chk(hold_req == 1'b1, "R10 request raised", hold_req, 1);
        @(negedge clk) req = 4'b0000;
        tick(2);
        chk(hold_req == 1'b1, "R10 still waiting through sync", hold_req, 1);
        tick(1);
        chk(hold_req == 1'b0 && gvalid == 1'b0, "R10 withdrawn returns idle", hold_req, 0);
    endtask

    initial begin
        rst_n = 1'b0; req = '0; dis = 1'b0; rot = 1'b0; ack_hi = 1'b0;
        hold_ack = 1'b0; done = 1'b0;
        t_reset();
        t_fixed();
        t_rotate();
        t_disable();
        t_polarity();
        t_withdraw();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule